// File: doc/BRIEF.md
# Double-Rate Output Stage with Tri-State Enable

This block serialises two parallel words per clock cycle onto one output bus at twice the clock rate. On every rising edge it captures a high word and a low word into two registers. A multiplexer selected by the clock level then presents the high word while the clock is high and the low word while the clock is low. Within each cycle the pin therefore carries the high word first and the low word second.

A separate path produces the enable for the external tri-state driver. The active-high request can be captured on the rising edge. It can also pass through a second register clocked on the falling edge. With that second register, turn-on is held back by half a cycle, which gives a strobe its write preamble, while turn-off still takes effect at once. A clock enable can freeze the data registers. Compile-time options add an asynchronous force input and a synchronous force input, each of which drives the data registers to all zeros or to all ones.

The asynchronous active-low reset is asserted at once and released through a short synchroniser.

Top module: `ddr_out_stage`

## Requirements
- R1: On each rising edge with `ce` high, both data registers capture `word_hi` and `word_lo` in the same edge.
- R2: `pad_data` equals the captured high word while `clk` is 1 and the captured low word while `clk` is 0, so the order within a cycle is high word, then low word.
- R3: On a rising edge with `ce` low and no force active, both data registers keep their values.
- R4: If `oe` is 0 at a rising edge, `pad_oe` is 0 for the whole following cycle. Switch-off is never delayed.
- R5: With the registered-enable option (default on), `oe` reaches `pad_oe` only through the rising edge that samples it.
- R6: With the half-cycle option (default on), the first cycle after `oe` rises keeps `pad_oe` at 0 during the high phase. `pad_oe` goes to 1 at the following falling edge.
- R7: While `rst_n` is 0, `pad_oe` is 0 and both data registers are 0. This holds at once, with no clock edge needed.
- R8: With the asynchronous force set to clear (the default), `async_force` = 1 drives both data registers to 0 without a clock edge. They stay 0 until the first rising edge after `async_force` returns to 0.
- R9: With the synchronous force set to set (the default), `sync_force` = 1 at a rising edge loads all ones into both data registers, even when `ce` is low.
- R10: After `rst_n` rises, the data registers stay in reset through the next two rising edges. The third rising edge is the first one that loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock. Its level also selects the word on `pad_data`. |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously. |
| ce | input | 1 | Clock enable for the data registers. |
| oe | input | 1 | Active-high output enable request. |
| async_force | input | 1 | Asynchronous clear or set of the data registers. |
| sync_force | input | 1 | Synchronous clear or set of the data registers. |
| word_hi | input | WIDTH | Word sent during the high clock phase. |
| word_lo | input | WIDTH | Word sent during the low clock phase. |
| pad_data | output | WIDTH | Double-rate data towards the pad driver. |
| pad_oe | output | 1 | Enable of the tri-state driver; 0 means high impedance. |

## Verification
The bench samples every cycle twice, once in mid-high phase and once in mid-low phase. A design that swapped the multiplexer polarity, or loaded the two words on different edges, fails in the phase it gets wrong. The enable is checked in both phases while `oe` rises, falls and toggles every cycle. A design that delayed switch-off shows a stray low-phase drive, and one without the falling-edge register drives during the high phase of the preamble cycle. The asynchronous force is raised between edges and held across an edge, which catches a force that is really synchronous or one that releases without waiting for an edge. Reset release is timed edge by edge, so a synchroniser with the wrong depth loads one cycle early or late.

// File: rtl/ddr_out_pkg.sv
`timescale 1ns/1ps
package ddr_out_pkg;
  // Kind of forcing applied to the data registers by a force input.
  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_LOW  = 2'd1,
    FORCE_HIGH = 2'd2
  } force_kind_e;
endpackage

// File: rtl/ddr_rst_sync.sv
`timescale 1ns/1ps
module ddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/ddr_word_regs.sv
`timescale 1ns/1ps
module ddr_word_regs
  import ddr_out_pkg::*;
#(
  parameter int          WIDTH        = 8,
  parameter bit          USE_CE       = 1'b1,
  parameter force_kind_e ASYNC_KIND   = FORCE_LOW,
  parameter force_kind_e SYNC_KIND    = FORCE_HIGH,
  parameter bit          POWERUP_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             async_force,
  input  logic             sync_force,
  input  logic [WIDTH-1:0] word_hi,
  input  logic [WIDTH-1:0] word_lo,
  output logic [WIDTH-1:0] hi_q,
  output logic [WIDTH-1:0] lo_q
);
  localparam bit HAS_ASYNC = (ASYNC_KIND != FORCE_NONE);
  localparam bit HAS_SYNC  = (SYNC_KIND != FORCE_NONE);
  localparam logic [WIDTH-1:0] RST_WORD   = {WIDTH{POWERUP_HIGH}};
  localparam logic [WIDTH-1:0] ASYNC_WORD = {WIDTH{ASYNC_KIND == FORCE_HIGH}};
  localparam logic [WIDTH-1:0] SYNC_WORD  = {WIDTH{SYNC_KIND == FORCE_HIGH}};

  logic             load_en;
  logic             sync_hit;
  logic             async_hit;
  logic [WIDTH-1:0] hi_d;
  logic [WIDTH-1:0] lo_d;

  // Next-state: a synchronous force wins over the clock enable.
  always_comb begin
    load_en   = USE_CE ? ce : 1'b1;
    sync_hit  = HAS_SYNC && sync_force;
    async_hit = HAS_ASYNC && async_force;
    if (sync_hit) begin
      hi_d = SYNC_WORD;
      lo_d = SYNC_WORD;
    end else if (load_en) begin
      hi_d = word_hi;
      lo_d = word_lo;
    end else begin
      hi_d = hi_q;
      lo_d = lo_q;
    end
  end

  generate
    if (HAS_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n or posedge async_force) begin
        if (!rst_n) begin
          hi_q <= RST_WORD;
          lo_q <= RST_WORD;
        end else if (async_force) begin
          hi_q <= ASYNC_WORD;
          lo_q <= ASYNC_WORD;
        end else begin
          hi_q <= hi_d;
          lo_q <= lo_d;
        end
      end

      // R8: while the asynchronous force is active, the registers hold its value
      p_async_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        async_hit |-> (hi_q == ASYNC_WORD && lo_q == ASYNC_WORD));
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= RST_WORD;
          lo_q <= RST_WORD;
        end else begin
          hi_q <= hi_d;
          lo_q <= lo_d;
        end
      end
    end

    if (HAS_SYNC) begin : g_sync_chk
      // R9: the synchronous force takes effect at the next edge, even with ce low
      p_sync_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sync_hit && !async_hit) |=>
          (!rst_n || async_hit || (hi_q == SYNC_WORD && lo_q == SYNC_WORD)));
    end
  endgenerate

  // R1: both words are captured together on an enabled edge
  p_load_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_en && !sync_hit && !async_hit) |=>
      (!rst_n || async_hit || (hi_q == $past(word_hi) && lo_q == $past(word_lo))));

  // R3: a disabled edge leaves both registers unchanged
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load_en && !sync_hit && !async_hit) |=>
      (!rst_n || async_hit || ($stable(hi_q) && $stable(lo_q))));
endmodule

// File: rtl/ddr_oe_path.sv
`timescale 1ns/1ps
module ddr_oe_path #(
  parameter bit REG_OE   = 1'b1,
  parameter bit DELAY_ON = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe,
  output logic drive
);
  logic rise_en;

  generate
    if (REG_OE) begin : g_reg
      logic rise_q;
      logic rise_d;
      always_comb rise_d = oe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_d;
      end
      assign rise_en = rise_q;
    end else begin : g_comb
      assign rise_en = oe;
    end

    if (DELAY_ON) begin : g_delay
      logic fall_q;
      logic fall_d;
      always_comb fall_d = rise_en;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
      end
      // The AND holds turn-on back by half a cycle and leaves turn-off immediate.
      assign drive = rise_en & fall_q;
    end else begin : g_direct
      assign drive = rise_en;
    end
  endgenerate
endmodule

// File: rtl/ddr_out_stage.sv
`timescale 1ns/1ps
module ddr_out_stage
  import ddr_out_pkg::*;
#(
  parameter int          WIDTH        = 8,
  parameter bit          USE_CE       = 1'b1,
  parameter bit          REG_OE       = 1'b1,
  parameter bit          DELAY_ON     = 1'b1,
  parameter force_kind_e ASYNC_KIND   = FORCE_LOW,
  parameter force_kind_e SYNC_KIND    = FORCE_HIGH,
  parameter bit          POWERUP_HIGH = 1'b0,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             oe,
  input  logic             async_force,
  input  logic             sync_force,
  input  logic [WIDTH-1:0] word_hi,
  input  logic [WIDTH-1:0] word_lo,
  output logic [WIDTH-1:0] pad_data,
  output logic             pad_oe
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr_word_regs #(
    .WIDTH        (WIDTH),
    .USE_CE       (USE_CE),
    .ASYNC_KIND   (ASYNC_KIND),
    .SYNC_KIND    (SYNC_KIND),
    .POWERUP_HIGH (POWERUP_HIGH)
  ) u_words (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ce          (ce),
    .async_force (async_force),
    .sync_force  (sync_force),
    .word_hi     (word_hi),
    .word_lo     (word_lo),
    .hi_q        (hi_q),
    .lo_q        (lo_q)
  );

  ddr_oe_path #(
    .REG_OE   (REG_OE),
    .DELAY_ON (DELAY_ON)
  ) u_oe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .oe    (oe),
    .drive (pad_oe)
  );

  // The clock level picks the word: high phase first, low phase second.
  assign pad_data = clk ? hi_q : lo_q;

  generate
    if (REG_OE) begin : g_oe_chk
      // R4: a low request at an edge leaves the driver off through that cycle
      p_off_now_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !oe |=> !pad_oe);
    end
    if (REG_OE && DELAY_ON) begin : g_pre_chk
      // R6: the high phase of the first enabled cycle stays high impedance
      p_preamble_r6: assert property (@(negedge clk) disable iff (!rst_sync_n)
        $rose(oe) |-> !pad_oe);
    end
  endgenerate
endmodule

// File: tb/tb_ddr_out_stage.sv
`timescale 1ns/1ps
module tb_ddr_out_stage;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce;
  logic       oe;
  logic       async_force;
  logic       sync_force;
  logic [7:0] word_hi;
  logic [7:0] word_lo;
  logic [7:0] pad_data;
  logic       pad_oe;

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_hi = 8'h00;
  logic [7:0] exp_lo = 8'h00;
  logic       prev_oe = 1'b0;

  always #10 clk = ~clk;

  ddr_out_stage #(.WIDTH(8)) dut (
    .clk (clk), .rst_n (rst_n), .ce (ce), .oe (oe),
    .async_force (async_force), .sync_force (sync_force),
    .word_hi (word_hi), .word_lo (word_lo),
    .pad_data (pad_data), .pad_oe (pad_oe)
  );

  // Stimulus fields: {oe, ce, high word, low word}
  localparam logic [17:0] VEC [0:11] = '{
    {1'b0, 1'b1, 8'hA1, 8'h5C},
    {1'b1, 1'b1, 8'h3C, 8'hC3},
    {1'b1, 1'b1, 8'hFF, 8'h00},
    {1'b1, 1'b0, 8'h12, 8'h34},
    {1'b1, 1'b1, 8'h81, 8'h18},
    {1'b0, 1'b1, 8'h77, 8'h88},
    {1'b1, 1'b0, 8'h9A, 8'hBC},
    {1'b1, 1'b1, 8'h01, 8'h80},
    {1'b0, 1'b0, 8'h55, 8'hAA},
    {1'b0, 1'b1, 8'h00, 8'hFF},
    {1'b1, 1'b1, 8'hE7, 8'h7E},
    {1'b0, 1'b1, 8'h11, 8'h22}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Apply one cycle of inputs, then check the high phase and the low phase.
  task automatic step(input logic s_oe, input logic s_ce, input logic s_sf,
                      input logic [7:0] s_hi, input logic [7:0] s_lo,
                      input logic s_loads, input string tag);
    logic dh;
    logic dl;
    string th;
    string tl;
    oe = s_oe; ce = s_ce; sync_force = s_sf; word_hi = s_hi; word_lo = s_lo;
    @(posedge clk);
    if (s_loads) begin
      if (s_sf) begin
        exp_hi = 8'hFF; exp_lo = 8'hFF;
      end else if (s_ce) begin
        exp_hi = s_hi; exp_lo = s_lo;
      end
    end
    dh = s_oe & prev_oe;
    dl = s_oe;
    th = (s_oe && !prev_oe) ? "R6 preamble high phase" : "R5 enable high phase";
    tl = s_oe ? "R5 enable low phase" : "R4 switch-off low phase";
    prev_oe = s_oe;
    #5;
    check({tag, " R2 data high phase"}, pad_data, exp_hi);
    check(th, pad_oe, dh);
    #10;
    check({tag, " R2 data low phase"}, pad_data, exp_lo);
    check(tl, pad_oe, dl);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("[TB] FAIL watchdog all actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; oe = 1'b0; async_force = 1'b0; sync_force = 1'b0;
    word_hi = 8'h00; word_lo = 8'h00;
    @(posedge clk);
    #15;
    // R7: reset state
    check("R7 reset drive", pad_oe, 1'b0);
    check("R7 reset data", pad_data, 8'h00);
    rst_n = 1'b1;

    // R10: two edges stay in reset, the third loads
    step(1'b0, 1'b1, 1'b0, 8'h5A, 8'hA5, 1'b0, "R10 edge1");
    step(1'b0, 1'b1, 1'b0, 8'h5A, 8'hA5, 1'b0, "R10 edge2");
    step(1'b0, 1'b1, 1'b0, 8'h5A, 8'hA5, 1'b1, "R10 edge3 R1");

    // Vector table: R1 load, R3 hold, R4/R5/R6 enable timing
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][17], VEC[i][16], 1'b0, VEC[i][15:8], VEC[i][7:0], 1'b1,
           VEC[i][16] ? "R1 load" : "R3 hold");
    end

    // R8: asynchronous clear between edges and across an edge
    oe = 1'b0; ce = 1'b1; sync_force = 1'b0; word_hi = 8'h3C; word_lo = 8'hC3;
    @(posedge clk);
    prev_oe = 1'b0;
    #5;
    check("R1 load before force", pad_data, 8'h3C);
    async_force = 1'b1;
    #1;
    check("R8 immediate clear", pad_data, 8'h00);
    #9;
    check("R8 clear low phase", pad_data, 8'h00);
    @(posedge clk);
    #5;
    check("R8 held across edge", pad_data, 8'h00);
    #10;
    async_force = 1'b0;
    #1;
    check("R8 release waits for edge", pad_data, 8'h00);
    exp_hi = 8'h00; exp_lo = 8'h00;
    step(1'b0, 1'b1, 1'b0, 8'h66, 8'h99, 1'b1, "R8 R1 reload after release");

    // R9: synchronous set with ce low, then R3 hold of the set value
    step(1'b0, 1'b0, 1'b1, 8'h12, 8'h34, 1'b1, "R9 sync set");
    step(1'b0, 1'b0, 1'b0, 8'h56, 8'h78, 1'b1, "R3 hold after set");

    // R7: reset asserted mid-run while driving
    step(1'b1, 1'b1, 1'b0, 8'hAA, 8'h55, 1'b1, "R1 pre-reset");
    step(1'b1, 1'b1, 1'b0, 8'h0F, 8'hF0, 1'b1, "R1 pre-reset");
    rst_n = 1'b0;
    #1;
    check("R7 drive off at reset", pad_oe, 1'b0);
    check("R7 data cleared at reset", pad_data, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule